// File: doc/BRIEF.md
# Predicate Register File with Write-Back Nullification

This block stores the one-bit qualifying predicates of a wide-issue core and uses them to cancel instructions at commit. Compare units write predicates through a small number of write ports. Each port can write a condition together with its complement, write a single condition alone, or combine two stored predicates with AND or OR. Combining lets a compound branch condition collapse into one bit.

Next to the file sits a registered commit-gating stage with one lane per issue slot. Each slot presents a valid bit, a predicate index, a write-back enable and an exception flag. One cycle later the stage passes the write-back enable and the exception through only when the selected predicate is true. When the predicate is false it raises a nullify flag instead, so the instruction retires as a NOP. The predicate value used at commit includes the writes made in the same cycle the slot was presented. A compare and the instructions it guards can therefore issue together.

Top module: `pred_nullify_unit`

## Requirements
- R1: After reset, predicate 0 reads as 1, every other predicate reads as 0, and all commit outputs are 0.
- R2: Predicate 0 always reads as 1, and every write aimed at it, as a true or a false target, is ignored.
- R3: Write mode 0 (pair) stores the port's condition into the true target and its inverse into the false target.
- R4: Write mode 3 (single) stores the condition into the true target only, and the false target keeps its value.
- R5: Write mode 1 (AND) stores src_a AND src_b into the true target and its inverse into the false target. The sources are the values held before the current cycle's writes.
- R6: Write mode 2 (OR) stores src_a OR src_b into the true target and its inverse into the false target.
- R7: When several writes in one cycle hit the same predicate, the higher-numbered port wins. Inside one port, the true target wins over the false target.
- R8: A valid slot whose predicate is true shows its write-back enable on cmt_wb_en exactly one clock after issue, with cmt_null low.
- R9: A valid slot whose predicate is false drives cmt_wb_en and cmt_exc low and cmt_null high one clock after issue.
- R10: A valid slot whose predicate is true passes its exception flag to cmt_exc one clock after issue.
- R11: A predicate written in cycle N qualifies the slots issued in that same cycle N, whose results appear in cycle N+1.
- R12: A slot that is not valid produces all-zero commit outputs, whatever its other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_WR | Write request per port |
| wr_mode | input | 2*NUM_WR | Per port mode: 0 pair, 1 AND, 2 OR, 3 single |
| wr_cond | input | NUM_WR | Compare result per port |
| wr_src_a | input | NUM_WR*IW | First combining source index per port |
| wr_src_b | input | NUM_WR*IW | Second combining source index per port |
| wr_dst_t | input | NUM_WR*IW | True target index per port |
| wr_dst_f | input | NUM_WR*IW | False target index per port |
| iss_valid | input | NUM_SLOT | Slot holds an instruction |
| iss_pidx | input | NUM_SLOT*IW | Qualifying predicate index per slot |
| iss_wb_en | input | NUM_SLOT | Instruction wants to write back |
| iss_exc | input | NUM_SLOT | Instruction raised an exception |
| cmt_wb_en | output | NUM_SLOT | Qualified write-back enable |
| cmt_exc | output | NUM_SLOT | Qualified exception |
| cmt_null | output | NUM_SLOT | Instruction nullified |

## Verification
Two functions can meet in one cycle: a predicate write and the gating of a slot that reads that same predicate. A second case is two write ports that target the same register. The bench triggers the first by issuing a pair write and slots indexed at both of its targets on the same clock edge. It checks that the slots commit using the freshly written values and not the stale ones. For the second, both ports aim at one predicate in one cycle, and a later read must return the higher port's value.

// File: rtl/pnu_pkg.sv
package pnu_pkg;

  typedef enum logic [1:0] {
    PW_PAIR   = 2'd0,
    PW_AND    = 2'd1,
    PW_OR     = 2'd2,
    PW_SINGLE = 2'd3
  } pw_mode_e;

  // Value bound for the true target of a write port.
  function automatic logic pw_value(pw_mode_e m, logic cond, logic a, logic b);
    case (m)
      PW_AND:  return a & b;
      PW_OR:   return a | b;
      default: return cond;
    endcase
  endfunction

  // Whether the port also writes the inverted value to its false target.
  function automatic logic pw_writes_false(pw_mode_e m);
    return m != PW_SINGLE;
  endfunction

  // Commit gating of one slot: {wb, exc, null}.
  function automatic logic [2:0] gate_slot(logic valid, logic pred, logic wb, logic exc);
    logic [2:0] r;
    r[2] = valid & pred & wb;
    r[1] = valid & pred & exc;
    r[0] = valid & ~pred;
    return r;
  endfunction

endpackage

// File: rtl/pnu_write_net.sv
module pnu_write_net
  import pnu_pkg::*;
#(
  parameter int NUM_PREDS = 64,
  parameter int NUM_WR    = 2,
  parameter int IW        = 6
) (
  input  logic [NUM_PREDS-1:0] cur,
  input  logic [NUM_WR-1:0]    en,
  input  logic [2*NUM_WR-1:0]  mode,
  input  logic [NUM_WR-1:0]    cond,
  input  logic [NUM_WR*IW-1:0] src_a,
  input  logic [NUM_WR*IW-1:0] src_b,
  input  logic [NUM_WR*IW-1:0] dst_t,
  input  logic [NUM_WR*IW-1:0] dst_f,
  output logic [NUM_WR-1:0]    port_val,
  output logic [NUM_PREDS-1:0] nxt
);

  // Per-port result from the stored (pre-write) state.
  for (genvar w = 0; w < NUM_WR; w++) begin : g_val
    assign port_val[w] = pw_value(pw_mode_e'(mode[w*2 +: 2]), cond[w],
                                  cur[src_a[w*IW +: IW]], cur[src_b[w*IW +: IW]]);
  end

  // Later ports overwrite earlier ones; true target overwrites false target.
  always_comb begin
    nxt = cur;
    for (int w = 0; w < NUM_WR; w++) begin
      if (en[w]) begin
        if (pw_writes_false(pw_mode_e'(mode[w*2 +: 2])))
          nxt[dst_f[w*IW +: IW]] = ~port_val[w];
        nxt[dst_t[w*IW +: IW]] = port_val[w];
      end
    end
    nxt[0] = 1'b1;
  end

endmodule

// File: rtl/pnu_pred_file.sv
module pnu_pred_file #(
  parameter int NUM_PREDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PREDS-1:0] nxt,
  output logic [NUM_PREDS-1:0] q
);

  logic [NUM_PREDS-1:1] store;

  always_ff @(posedge clk) begin
    if (!rst_n) store <= '0;
    else        store <= nxt[NUM_PREDS-1:1];
  end

  assign q = {store, 1'b1};

  // Stored bits only move when the next-state vector differs.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == q) |=> $stable(q));

endmodule

// File: rtl/pnu_gate_slot.sv
module pnu_gate_slot
  import pnu_pkg::*;
#(
  parameter int NUM_PREDS = 64,
  parameter int IW        = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [IW-1:0]        pidx,
  input  logic                 wb_en,
  input  logic                 exc,
  input  logic [NUM_PREDS-1:0] pv_byp,
  output logic                 wb_o,
  output logic                 exc_o,
  output logic                 null_o
);

  logic       pred_sel;
  logic [2:0] gated;

  assign pred_sel = pv_byp[pidx];
  assign gated    = gate_slot(valid, pred_sel, wb_en, exc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_o   <= 1'b0;
      exc_o  <= 1'b0;
      null_o <= 1'b0;
    end else begin
      wb_o   <= gated[2];
      exc_o  <= gated[1];
      null_o <= gated[0];
    end
  end

  assert_null_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    null_o |-> (!wb_o && !exc_o));

  assert_idle_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!wb_o && !exc_o && !null_o));

  assert_exc_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && exc && !pred_sel) |=> !exc_o);

  assert_wb_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && pred_sel) |=> (wb_o == $past(wb_en) && !null_o));

endmodule

// File: rtl/pred_nullify_unit.sv
module pred_nullify_unit
  import pnu_pkg::*;
#(
  parameter int NUM_PREDS = 64,
  parameter int NUM_WR    = 2,
  parameter int NUM_SLOT  = 4,
  localparam int IW       = $clog2(NUM_PREDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WR-1:0]      wr_en,
  input  logic [2*NUM_WR-1:0]    wr_mode,
  input  logic [NUM_WR-1:0]      wr_cond,
  input  logic [NUM_WR*IW-1:0]   wr_src_a,
  input  logic [NUM_WR*IW-1:0]   wr_src_b,
  input  logic [NUM_WR*IW-1:0]   wr_dst_t,
  input  logic [NUM_WR*IW-1:0]   wr_dst_f,
  input  logic [NUM_SLOT-1:0]    iss_valid,
  input  logic [NUM_SLOT*IW-1:0] iss_pidx,
  input  logic [NUM_SLOT-1:0]    iss_wb_en,
  input  logic [NUM_SLOT-1:0]    iss_exc,
  output logic [NUM_SLOT-1:0]    cmt_wb_en,
  output logic [NUM_SLOT-1:0]    cmt_exc,
  output logic [NUM_SLOT-1:0]    cmt_null
);

  localparam int TOP = NUM_WR - 1;

  logic [NUM_PREDS-1:0] pred_q;
  logic [NUM_PREDS-1:0] pred_nxt;
  logic [NUM_WR-1:0]    port_val;

  pnu_write_net #(.NUM_PREDS(NUM_PREDS), .NUM_WR(NUM_WR), .IW(IW)) u_wnet (
    .cur(pred_q), .en(wr_en), .mode(wr_mode), .cond(wr_cond),
    .src_a(wr_src_a), .src_b(wr_src_b), .dst_t(wr_dst_t), .dst_f(wr_dst_f),
    .port_val(port_val), .nxt(pred_nxt)
  );

  pnu_pred_file #(.NUM_PREDS(NUM_PREDS)) u_file (
    .clk(clk), .rst_n(rst_n), .nxt(pred_nxt), .q(pred_q)
  );

  // Gating reads the next-state vector: same-cycle writes are bypassed.
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    pnu_gate_slot #(.NUM_PREDS(NUM_PREDS), .IW(IW)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .valid(iss_valid[s]), .pidx(iss_pidx[s*IW +: IW]),
      .wb_en(iss_wb_en[s]), .exc(iss_exc[s]), .pv_byp(pred_nxt),
      .wb_o(cmt_wb_en[s]), .exc_o(cmt_exc[s]), .null_o(cmt_null[s])
    );

    assert_p0_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[s] && iss_pidx[s*IW +: IW] == '0) |=> !cmt_null[s]);
  end

  assert_top_port_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[TOP] && wr_dst_t[TOP*IW +: IW] != '0)
    |=> pred_q[$past(wr_dst_t[TOP*IW +: IW])] == $past(port_val[TOP]));

  assert_pair_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[TOP] && wr_mode[TOP*2 +: 2] != 2'd3 &&
     wr_dst_t[TOP*IW +: IW] != wr_dst_f[TOP*IW +: IW] &&
     wr_dst_t[TOP*IW +: IW] != '0 && wr_dst_f[TOP*IW +: IW] != '0)
    |=> pred_q[$past(wr_dst_t[TOP*IW +: IW])] != pred_q[$past(wr_dst_f[TOP*IW +: IW])]);

endmodule

// File: tb/pred_nullify_unit_bench.sv
module pred_nullify_unit_bench;

  localparam int NP = 64;
  localparam int NW = 2;
  localparam int NS = 4;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    wr_en;
  logic [2*NW-1:0]  wr_mode;
  logic [NW-1:0]    wr_cond;
  logic [NW*IW-1:0] wr_src_a, wr_src_b, wr_dst_t, wr_dst_f;
  logic [NS-1:0]    iss_valid, iss_wb_en, iss_exc;
  logic [NS*IW-1:0] iss_pidx;
  logic [NS-1:0]    cmt_wb_en, cmt_exc, cmt_null;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pred_nullify_unit #(.NUM_PREDS(NP), .NUM_WR(NW), .NUM_SLOT(NS)) u_pred_nullify_unit (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_cond(wr_cond),
    .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_dst_t(wr_dst_t), .wr_dst_f(wr_dst_f),
    .iss_valid(iss_valid), .iss_pidx(iss_pidx), .iss_wb_en(iss_wb_en), .iss_exc(iss_exc),
    .cmt_wb_en(cmt_wb_en), .cmt_exc(cmt_exc), .cmt_null(cmt_null)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = '0; wr_mode = '0; wr_cond = '0;
    wr_src_a = '0; wr_src_b = '0; wr_dst_t = '0; wr_dst_f = '0;
    iss_valid = '0; iss_pidx = '0; iss_wb_en = '0; iss_exc = '0;
  endtask

  task automatic begin_cycle();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic end_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic set_wr(int p, logic [1:0] m, logic c, int a, int b, int t, int f);
    wr_en[p] = 1'b1;
    wr_mode[p*2 +: 2] = m;
    wr_cond[p] = c;
    wr_src_a[p*IW +: IW] = IW'(a);
    wr_src_b[p*IW +: IW] = IW'(b);
    wr_dst_t[p*IW +: IW] = IW'(t);
    wr_dst_f[p*IW +: IW] = IW'(f);
  endtask

  task automatic set_slot(int s, int k, logic wb, logic ex);
    iss_valid[s] = 1'b1;
    iss_pidx[s*IW +: IW] = IW'(k);
    iss_wb_en[s] = wb;
    iss_exc[s] = ex;
  endtask

  task automatic write_cycle(int p, logic [1:0] m, logic c, int a, int b, int t, int f);
    begin_cycle();
    set_wr(p, m, c, a, b, t, f);
    end_cycle();
  endtask

  // Reads predicate k through slot 0.
  task automatic expect_pred(string req, int k, logic exp);
    begin_cycle();
    set_slot(0, k, 1'b1, 1'b0);
    end_cycle();
    check(req, cmt_wb_en[0], exp);
  endtask

  task automatic t_reset();
    check("R1 cmt_wb_en after reset", |cmt_wb_en, 1'b0);
    check("R1 cmt_exc after reset", |cmt_exc, 1'b0);
    check("R1 cmt_null after reset", |cmt_null, 1'b0);
    expect_pred("R1 p0 reset", 0, 1'b1);
    expect_pred("R1 p5 reset", 5, 1'b0);
    expect_pred("R1 p63 reset", 63, 1'b0);
  endtask

  task automatic t_p0();
    write_cycle(1, 2'd3, 1'b0, 0, 0, 0, 0);
    expect_pred("R2 p0 after true-target write", 0, 1'b1);
    write_cycle(0, 2'd0, 1'b1, 0, 0, 2, 0);
    expect_pred("R2 p0 after false-target write", 0, 1'b1);
    expect_pred("R2 p2 neighbour written", 2, 1'b1);
  endtask

  task automatic t_pair();
    write_cycle(0, 2'd0, 1'b1, 0, 0, 3, 4);
    expect_pred("R3 pair true", 3, 1'b1);
    expect_pred("R3 pair false", 4, 1'b0);
    write_cycle(1, 2'd0, 1'b0, 0, 0, 3, 4);
    expect_pred("R3 pair true cond0", 3, 1'b0);
    expect_pred("R3 pair false cond0", 4, 1'b1);
  endtask

  task automatic t_single();
    write_cycle(0, 2'd0, 1'b1, 0, 0, 7, 9);
    write_cycle(1, 2'd3, 1'b1, 0, 0, 8, 7);
    expect_pred("R4 single target", 8, 1'b1);
    expect_pred("R4 single false untouched", 7, 1'b1);
  endtask

  task automatic t_and();
    // p7=1 p8=1 p9=0
    write_cycle(0, 2'd1, 1'b0, 7, 8, 10, 11);
    expect_pred("R5 and 1&1 true", 10, 1'b1);
    expect_pred("R5 and 1&1 false", 11, 1'b0);
    write_cycle(1, 2'd1, 1'b1, 7, 9, 12, 13);
    expect_pred("R5 and 1&0 true", 12, 1'b0);
    expect_pred("R5 and 1&0 false", 13, 1'b1);
    // port 0 clears p7 while port 1 combines the old p7
    begin_cycle();
    set_wr(0, 2'd0, 1'b0, 0, 0, 7, 25);
    set_wr(1, 2'd1, 1'b0, 7, 8, 26, 27);
    end_cycle();
    expect_pred("R5 and uses stored source", 26, 1'b1);
    expect_pred("R5 same-cycle source write landed", 7, 1'b0);
  endtask

  task automatic t_or();
    // p9=0 p11=0 p8=1
    write_cycle(0, 2'd2, 1'b1, 9, 11, 14, 15);
    expect_pred("R6 or 0|0 true", 14, 1'b0);
    expect_pred("R6 or 0|0 false", 15, 1'b1);
    write_cycle(1, 2'd2, 1'b0, 9, 8, 16, 17);
    expect_pred("R6 or 0|1 true", 16, 1'b1);
    expect_pred("R6 or 0|1 false", 17, 1'b0);
  endtask

  task automatic t_conflict();
    begin_cycle();
    set_wr(0, 2'd0, 1'b1, 0, 0, 20, 21);
    set_wr(1, 2'd0, 1'b0, 0, 0, 21, 22);
    end_cycle();
    expect_pred("R7 port1 wins p21", 21, 1'b0);
    expect_pred("R7 port0 other target p20", 20, 1'b1);
    expect_pred("R7 port1 false p22", 22, 1'b1);
    begin_cycle();
    set_wr(0, 2'd3, 1'b1, 0, 0, 23, 0);
    set_wr(1, 2'd3, 1'b0, 0, 0, 23, 0);
    end_cycle();
    expect_pred("R7 single conflict", 23, 1'b0);
    write_cycle(0, 2'd0, 1'b1, 0, 0, 24, 24);
    expect_pred("R7 true target beats false", 24, 1'b1);
  endtask

  task automatic t_commit_pass();
    // p4=1
    begin_cycle();
    set_slot(2, 4, 1'b1, 1'b0);
    #1;
    check("R8 no output before edge", cmt_wb_en[2], 1'b0);
    end_cycle();
    check("R8 wb passes", cmt_wb_en[2], 1'b1);
    check("R8 not nullified", cmt_null[2], 1'b0);
    begin_cycle();
    end_cycle();
    check("R8 one cycle only", cmt_wb_en[2], 1'b0);
  endtask

  task automatic t_null();
    // p3=0
    begin_cycle();
    set_slot(3, 3, 1'b1, 1'b1);
    end_cycle();
    check("R9 wb suppressed", cmt_wb_en[3], 1'b0);
    check("R9 exc suppressed", cmt_exc[3], 1'b0);
    check("R9 null flagged", cmt_null[3], 1'b1);
  endtask

  task automatic t_exc();
    begin_cycle();
    set_slot(1, 4, 1'b0, 1'b1);
    end_cycle();
    check("R10 exc passes", cmt_exc[1], 1'b1);
    check("R10 wb stays low", cmt_wb_en[1], 1'b0);
    check("R10 not nullified", cmt_null[1], 1'b0);
  endtask

  task automatic t_bypass();
    begin_cycle();
    set_wr(0, 2'd0, 1'b1, 0, 0, 30, 31);
    set_wr(1, 2'd3, 1'b0, 0, 0, 4, 0);
    set_slot(0, 30, 1'b1, 1'b0);
    set_slot(1, 31, 1'b1, 1'b0);
    set_slot(2, 4, 1'b1, 1'b0);
    end_cycle();
    check("R11 fresh true used", cmt_wb_en[0], 1'b1);
    check("R11 fresh false nullifies", cmt_null[1], 1'b1);
    check("R11 overwrite of p4 nullifies", cmt_null[2], 1'b1);
  endtask

  task automatic t_invalid();
    begin_cycle();
    iss_valid = '0;
    iss_pidx = '0;
    iss_wb_en = '1;
    iss_exc = '1;
    end_cycle();
    check("R12 invalid wb", |cmt_wb_en, 1'b0);
    check("R12 invalid exc", |cmt_exc, 1'b0);
    check("R12 invalid null", |cmt_null, 1'b0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_p0();
    t_pair();
    t_single();
    t_and();
    t_or();
    t_conflict();
    t_commit_pass();
    t_null();
    t_exc();
    t_bypass();
    t_invalid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule